// File: doc/BRIEF.md
# Descriptor Ring Source Engine

This block drains a circular ring of transmit descriptors kept in a small local descriptor store. Software fills descriptor slots through a write port and then publishes a producer index. The engine walks the ring from its own read index up to that producer index. For each descriptor it presents one transfer request on a valid/acknowledge port, and it steps its read index once the port accepts the request. Software reads the index back to reclaim finished slots.

Descriptors whose chain bit is set are joined to the descriptors that follow them. The whole chain goes out as one framed transfer. The frame is marked by first and last flags, and it produces a single completion pulse that carries the summed byte count. The ring size is a runtime power of two, and indices wrap by masking. The free-slot count the engine reports always leaves one slot empty, so that a full ring is never confused with an empty one. A ring size of zero turns the engine off.

Top module: `rse_top`

## Requirements
- R1: After reset, `hw_rd_idx` is 0, and `req_valid` and `done` are low.
- R2: While `cfg_size` is 0, no request is issued whatever `sw_wr_idx` holds, and `hw_rd_idx` is held at 0.
- R3: While `hw_rd_idx` differs from `sw_wr_idx & (cfg_size-1)`, `req_valid` is high and presents the slot at `hw_rd_idx`. `req_addr` and `req_len` come from the slot. The flags word is decoded as bit 0 = chain, bit 1 = byte swap (driven on `req_swap`), and bits 15:8 = transfer id.
- R4: `hw_rd_idx` advances by exactly one, modulo the ring size, on each cycle with `req_valid` and `req_ack` both high. While a request waits without acknowledge, the index and the request fields stay unchanged.
- R5: The index that follows `cfg_size-1` is 0.
- R6: In a chain, only the first descriptor shows `req_first`, and only the final descriptor (chain bit clear) shows `req_last`. Exactly one `done` pulse follows, one cycle after the final acknowledge. It carries `done_bytes` equal to the sum of the chain's byte counts and `done_tid` equal to the final descriptor's id.
- R7: A single descriptor with its chain bit clear shows both `req_first` and `req_last`. Its acknowledge yields a `done` pulse, one cycle later, with its own byte count and id.
- R8: `free_slots` equals `(hw_rd_idx - 1 - sw_wr_idx) & (cfg_size-1)`, so a ring holding `cfg_size-1` descriptors reports 0.
- R9: `req_oversize` is high exactly when the presented byte count exceeds `cfg_max_len`. The request is still issued.
- R10: When `hw_rd_idx` equals the masked producer index, `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_size | input | IDX_W+1 | Ring entries (0 or a power of two up to DEPTH) |
| cfg_max_len | input | 16 | Largest allowed byte count |
| dsc_we | input | 1 | Descriptor slot write strobe |
| dsc_slot | input | IDX_W | Slot being written |
| dsc_addr | input | 32 | Buffer address for the slot |
| dsc_len | input | 16 | Byte count for the slot |
| dsc_flags | input | 16 | Flags word for the slot |
| sw_wr_idx | input | IDX_W | Published producer index |
| hw_rd_idx | output | IDX_W | Engine read index |
| free_slots | output | IDX_W | Slots software may still fill |
| req_valid | output | 1 | Transfer request present |
| req_ack | input | 1 | Request accepted |
| req_addr | output | 32 | Buffer address of the request |
| req_len | output | 16 | Byte count of the request |
| req_swap | output | 1 | Reverse bytes within each 32-bit word |
| req_first | output | 1 | Request opens a transfer |
| req_last | output | 1 | Request closes a transfer |
| req_tid | output | 8 | Transfer id of the request |
| req_oversize | output | 1 | Byte count above the limit |
| done | output | 1 | One-cycle completion pulse |
| done_tid | output | 8 | Id of the completed transfer |
| done_bytes | output | SUM_W | Total bytes of the completed transfer |

## Verification
The assertions assume that `cfg_size` stays constant while the engine runs. They also assume that `sw_wr_idx` only moves forward and never passes the read index, and that software writes only to slots outside the span between the read and producer indices. This keeps a waiting request stable. The directed tasks configure the size only while the ring is drained. They fill slots first and publish the producer index afterwards, and they never post more than `cfg_size-1` descriptors ahead of the engine.

// File: rtl/rse_pkg.sv
package rse_pkg;
    localparam int FLAG_CHAIN = 0;
    localparam int FLAG_SWAP  = 1;
    localparam int TID_LSB    = 8;
    localparam int TID_W      = 8;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [15:0] flags;
    } desc_t;
endpackage

// File: rtl/rse_desc_mem.sv
module rse_desc_mem
    import rse_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wslot,
    input  desc_t            wdata,
    input  logic [IDX_W-1:0] rslot,
    output desc_t            rdata
);
    desc_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wslot] <= wdata;
        end
    end

    assign rdata = mem_q[rslot];
endmodule

// File: rtl/rse_walker.sv
module rse_walker
    import rse_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int SUM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   cfg_size,
    input  logic [15:0]      cfg_max_len,
    input  logic [IDX_W-1:0] sw_wr_idx,
    input  desc_t            cur,
    input  logic             req_ack,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] free_slots,
    output logic             req_valid,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic             req_swap,
    output logic             req_first,
    output logic             req_last,
    output logic [TID_W-1:0] req_tid,
    output logic             req_oversize,
    output logic             done,
    output logic [TID_W-1:0] done_tid,
    output logic [SUM_W-1:0] done_bytes
);
    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic             in_chain;
        logic [SUM_W-1:0] acc;
        logic             done;
        logic [TID_W-1:0] done_tid;
        logic [SUM_W-1:0] done_bytes;
    } st_t;

    st_t st_d, st_q;

    logic             enable;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] wr_m;
    logic             fire;
    logic             chain_bit;

    always_comb begin
        enable    = (cfg_size != '0);
        mask      = cfg_size[IDX_W-1:0] - 1'b1;
        wr_m      = sw_wr_idx & mask;
        chain_bit = cur.flags[FLAG_CHAIN];
        req_valid = enable && (st_q.rd != wr_m);
        fire      = req_valid && req_ack;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!enable) begin
            st_d.rd       = '0;
            st_d.in_chain = 1'b0;
            st_d.acc      = '0;
        end else if (fire) begin
            st_d.rd = (st_q.rd + 1'b1) & mask;
            if (chain_bit) begin
                st_d.in_chain = 1'b1;
                st_d.acc      = st_q.acc + SUM_W'(cur.len);
            end else begin
                st_d.in_chain   = 1'b0;
                st_d.acc        = '0;
                st_d.done       = 1'b1;
                st_d.done_tid   = cur.flags[TID_LSB +: TID_W];
                st_d.done_bytes = st_q.acc + SUM_W'(cur.len);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_idx       = st_q.rd;
    assign free_slots   = (st_q.rd - 1'b1 - sw_wr_idx) & mask;
    assign req_addr     = cur.addr;
    assign req_len      = cur.len;
    assign req_swap     = cur.flags[FLAG_SWAP];
    assign req_first    = !st_q.in_chain;
    assign req_last     = !chain_bit;
    assign req_tid      = cur.flags[TID_LSB +: TID_W];
    assign req_oversize = cur.len > cfg_max_len;
    assign done         = st_q.done;
    assign done_tid     = st_q.done_tid;
    assign done_bytes   = st_q.done_bytes;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size == '0) |-> !req_valid); // R2
    AST_STEP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n || cfg_size == '0)
        (req_valid && req_ack) |=> rd_idx == (($past(rd_idx) + 1'b1) & $past(mask))); // R4
    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n || cfg_size == '0)
        (req_valid && !req_ack) |=> (req_valid && $stable(rd_idx) && $stable(req_addr))); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && req_ack && req_last)); // R6
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == (sw_wr_idx & mask)) |-> !req_valid); // R10
endmodule

// File: rtl/rse_top.sv
module rse_top
    import rse_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SUM_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   cfg_size,
    input  logic [15:0]      cfg_max_len,
    input  logic             dsc_we,
    input  logic [IDX_W-1:0] dsc_slot,
    input  logic [31:0]      dsc_addr,
    input  logic [15:0]      dsc_len,
    input  logic [15:0]      dsc_flags,
    input  logic [IDX_W-1:0] sw_wr_idx,
    output logic [IDX_W-1:0] hw_rd_idx,
    output logic [IDX_W-1:0] free_slots,
    output logic             req_valid,
    input  logic             req_ack,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic             req_swap,
    output logic             req_first,
    output logic             req_last,
    output logic [7:0]       req_tid,
    output logic             req_oversize,
    output logic             done,
    output logic [7:0]       done_tid,
    output logic [SUM_W-1:0] done_bytes
);
    desc_t wdesc, cur;

    assign wdesc = '{addr: dsc_addr, len: dsc_len, flags: dsc_flags};

    rse_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dsc_we),
        .wslot (dsc_slot),
        .wdata (wdesc),
        .rslot (hw_rd_idx),
        .rdata (cur)
    );

    rse_walker #(.IDX_W(IDX_W), .SUM_W(SUM_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_size     (cfg_size),
        .cfg_max_len  (cfg_max_len),
        .sw_wr_idx    (sw_wr_idx),
        .cur          (cur),
        .req_ack      (req_ack),
        .rd_idx       (hw_rd_idx),
        .free_slots   (free_slots),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_swap     (req_swap),
        .req_first    (req_first),
        .req_last     (req_last),
        .req_tid      (req_tid),
        .req_oversize (req_oversize),
        .done         (done),
        .done_tid     (done_tid),
        .done_bytes   (done_bytes)
    );
endmodule

// File: tb/rse_top_tb.sv
module rse_top_tb;
    localparam int DEPTH = 16;
    localparam int IDX_W = 4;
    localparam int SUM_W = 20;

    logic             clk = 0;
    logic             rst_n = 0;
    logic [IDX_W:0]   cfg_size = '0;
    logic [15:0]      cfg_max_len = 16'hFFFF;
    logic             dsc_we = 0;
    logic [IDX_W-1:0] dsc_slot = '0;
    logic [31:0]      dsc_addr = '0;
    logic [15:0]      dsc_len = '0;
    logic [15:0]      dsc_flags = '0;
    logic [IDX_W-1:0] sw_wr_idx = '0;
    logic             req_ack = 0;
    logic [IDX_W-1:0] hw_rd_idx, free_slots;
    logic             req_valid, req_swap, req_first, req_last, req_oversize, done;
    logic [31:0]      req_addr;
    logic [15:0]      req_len;
    logic [7:0]       req_tid, done_tid;
    logic [SUM_W-1:0] done_bytes;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rse_top #(.DEPTH(DEPTH), .SUM_W(SUM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_max_len(cfg_max_len),
        .dsc_we(dsc_we), .dsc_slot(dsc_slot), .dsc_addr(dsc_addr), .dsc_len(dsc_len),
        .dsc_flags(dsc_flags), .sw_wr_idx(sw_wr_idx), .hw_rd_idx(hw_rd_idx),
        .free_slots(free_slots), .req_valid(req_valid), .req_ack(req_ack),
        .req_addr(req_addr), .req_len(req_len), .req_swap(req_swap),
        .req_first(req_first), .req_last(req_last), .req_tid(req_tid),
        .req_oversize(req_oversize), .done(done), .done_tid(done_tid),
        .done_bytes(done_bytes)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic post(input logic [IDX_W-1:0] slot, input logic [31:0] a,
                        input logic [15:0] len, input logic [15:0] fl);
        dsc_we = 1; dsc_slot = slot; dsc_addr = a; dsc_len = len; dsc_flags = fl;
        @(posedge clk); @(negedge clk);
        dsc_we = 0;
    endtask

    task automatic ack_once();
        req_ack = 1;
        @(posedge clk); @(negedge clk);
        req_ack = 0;
    endtask

    task automatic t_reset();
        check("R1 rd", 32'(hw_rd_idx), 0);
        check("R1 valid", 32'(req_valid), 0);
        check("R1 done", 32'(done), 0);
    endtask

    task automatic t_disabled();
        int seen = 0;
        sw_wr_idx = 4'd3;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_valid) seen++;
        end
        check("R2 no request while off", 32'(seen), 0);
        check("R2 rd held", 32'(hw_rd_idx), 0);
        sw_wr_idx = 4'd0;
        @(negedge clk);
    endtask

    task automatic t_single();
        cfg_size = 5'd4;
        post(4'd0, 32'hA000_0010, 16'd100, 16'h0502);
        @(negedge clk);
        check("R10 empty idle", 32'(req_valid), 0);
        sw_wr_idx = 4'd1;
        @(negedge clk);
        check("R3 valid", 32'(req_valid), 1);
        check("R3 addr", req_addr, 32'hA000_0010);
        check("R3 len", 32'(req_len), 100);
        check("R3 swap", 32'(req_swap), 1);
        check("R3 tid", 32'(req_tid), 5);
        check("R7 first", 32'(req_first), 1);
        check("R7 last", 32'(req_last), 1);
        check("R8 free", 32'(free_slots), 2);
        @(negedge clk); @(negedge clk);
        check("R4 hold rd", 32'(hw_rd_idx), 0);
        check("R4 hold addr", req_addr, 32'hA000_0010);
        ack_once();
        check("R4 step", 32'(hw_rd_idx), 1);
        check("R7 done", 32'(done), 1);
        check("R7 bytes", 32'(done_bytes), 100);
        check("R7 tid", 32'(done_tid), 5);
        check("R10 drained", 32'(req_valid), 0);
        @(negedge clk);
        check("R7 single pulse", 32'(done), 0);
    endtask

    task automatic t_gather();
        post(4'd1, 32'h100, 16'd10, 16'h0001);
        post(4'd2, 32'h200, 16'd20, 16'h0001);
        post(4'd3, 32'h300, 16'd30, 16'h0900);
        check("R8 free before", 32'(free_slots), 3);
        sw_wr_idx = 4'd0;
        @(negedge clk);
        check("R8 full", 32'(free_slots), 0);
        check("R6 first of chain", 32'(req_first), 1);
        check("R6 not last", 32'(req_last), 0);
        ack_once();
        check("R6 no early done", 32'(done), 0);
        check("R6 mid first", 32'(req_first), 0);
        check("R6 mid last", 32'(req_last), 0);
        check("R6 mid addr", req_addr, 32'h200);
        ack_once();
        check("R6 no mid done", 32'(done), 0);
        check("R6 final last", 32'(req_last), 1);
        check("R6 final first", 32'(req_first), 0);
        ack_once();
        check("R6 done", 32'(done), 1);
        check("R6 bytes", 32'(done_bytes), 60);
        check("R6 tid", 32'(done_tid), 9);
        check("R5 wrap", 32'(hw_rd_idx), 0);
        check("R10 drained", 32'(req_valid), 0);
    endtask

    task automatic t_oversize();
        cfg_max_len = 16'd64;
        post(4'd0, 32'h400, 16'd65, 16'h0000);
        post(4'd1, 32'h500, 16'd64, 16'h0000);
        sw_wr_idx = 4'd6;
        @(negedge clk);
        check("R9 over", 32'(req_oversize), 1);
        check("R9 still issued", 32'(req_valid), 1);
        ack_once();
        check("R9 at limit", 32'(req_oversize), 0);
        check("R3 masked producer", 32'(req_valid), 1);
        ack_once();
        check("R3 masked stop", 32'(req_valid), 0);
        check("R4 rd", 32'(hw_rd_idx), 2);
    endtask

    task automatic t_off_again();
        cfg_size = '0;
        sw_wr_idx = 4'd1;
        @(negedge clk); @(negedge clk);
        check("R2 rd cleared", 32'(hw_rd_idx), 0);
        check("R2 idle", 32'(req_valid), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset();
                t_disabled();
                t_single();
                t_gather();
                t_oversize();
                t_off_again();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule